// File: doc/BRIEF.md
# Smart-Card Answer-to-Reset Initial Character Monitor

This block passively observes the contact lines of a smart card: supply, card reset, card clock and the bytes delivered by an external serial receiver. It judges whether the card is powered and clocked. From the moment the card reset line is released, it counts rising edges of the card clock, not of its own system clock. It then treats the first byte that the receiver delivers as the initial character of the answer-to-reset.

From the raw value of that character the monitor works out the coding convention. In the direct convention bits arrive least-significant first and a high line means one. In the inverse convention bits arrive most-significant first and a high line means zero. The monitor also stores the character's decoded value. Two timing windows, measured in card clock cycles after reset release, mark the character as early or late. Any value other than the two legal patterns is reported as an error.

The block runs on a system clock that must be several times faster than the card clock. The three card lines pass through a synchronizer. The receiver strobe and data are taken as already synchronous to the system clock.

Top module: `atr_ts_monitor`

## Requirements
- R1: While the synchronized supply line is low or the synchronized card reset line is low, ts_seen, ts_bad, inverse_conv, atr_early, atr_late and ts_byte are all held at zero, and receiver strobes are ignored.
- R2: activated rises after the supply is high and a rising card clock edge has been seen, whatever the card reset line does; it falls when the supply goes low.
- R3: A first raw byte of 0x3B sets ts_seen, leaves inverse_conv at 0 and ts_bad at 0, and stores 0x3B in ts_byte.
- R4: A first raw byte of 0x03 sets ts_seen and inverse_conv, and stores the inverted, bit-reversed value 0x3F in ts_byte.
- R5: Any other first raw byte sets ts_seen and ts_bad, leaves inverse_conv at 0, and stores the raw byte in ts_byte.
- R6: atr_early is set when the first byte arrives while fewer than EARLY_CYCLES (default 400) card clock rising edges have been counted since reset release.
- R7: atr_early stays 0 when the first byte arrives after EARLY_CYCLES or more edges.
- R8: atr_late is set once LATE_CYCLES (default 40000) edges have been counted with no byte received, and it stays set when the byte arrives afterwards.
- R9: The edge counter saturates at LATE_CYCLES; atr_late stays set however many further edges arrive.
- R10: Only the first byte after reset release is taken; later strobes leave ts_byte, inverse_conv and ts_bad unchanged.
- R11: A new card reset assertion clears every sticky flag, and the next release starts a fresh measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| card_vcc | input | 1 | Card supply line, high when powered |
| card_rst_n | input | 1 | Card reset line, low while reset is asserted |
| card_clk | input | 1 | Card clock line |
| rx_valid | input | 1 | One-cycle strobe from the receiver: a byte is available |
| rx_data | input | 8 | Raw byte from the receiver, read as direct convention |
| activated | output | 1 | Card powered and clocked |
| ts_seen | output | 1 | Initial character received |
| ts_bad | output | 1 | Initial character had an illegal value |
| inverse_conv | output | 1 | Inverse convention selected |
| ts_byte | output | 8 | Decoded initial character |
| atr_early | output | 1 | Initial character came before the early window ended |
| atr_late | output | 1 | Late window expired before the initial character |

## Verification
On every cycle the assertions check several properties. The flags clear while the card is held in reset. activated drops after supply loss. The late flag stays sticky, and the edge counter never passes its limit. A captured character and its convention do not move again, an early mark always comes with a received character, and an error never comes with the inverse flag. The bench scenarios are the only place where the exact window boundaries show: one edge short of the early limit against exactly at it, and one edge short of the late limit against exactly at it. The scenarios also show the decoding of each legal pattern, behaviour after the counter would have wrapped, and re-arming after a new reset.

// File: rtl/atr_ts_pkg.sv
package atr_ts_pkg;

    typedef enum logic [1:0] {
        ST_WAIT    = 2'd0,
        ST_OVERDUE = 2'd1,
        ST_DONE    = 2'd2
    } mon_state_t;

    typedef enum logic [1:0] {
        TS_DIRECT  = 2'd0,
        TS_INVERSE = 2'd1,
        TS_INVALID = 2'd2
    } ts_kind_t;

    localparam logic [7:0] RAW_TS_DIRECT  = 8'h3B;
    localparam logic [7:0] RAW_TS_INVERSE = 8'h03;

endpackage

// File: rtl/card_line_sync.sv
module card_line_sync #(
    parameter int STAGES = 2,
    parameter int W      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lines_in,
    output logic [W-1:0] lines_s
);
    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], lines_in};
        end
    end

    assign lines_s = stage_q[STAGES-1];
endmodule

// File: rtl/card_cycle_counter.sv
module card_cycle_counter #(
    parameter int LIMIT = 40000,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             card_clk_s,
    output logic             clk_rise,
    output logic [CNT_W-1:0] count,
    output logic             at_limit
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= card_clk_s;
        end
    end

    assign clk_rise = card_clk_s & ~prev_q;
    assign at_limit = (count == CNT_W'(LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (clk_rise && !at_limit) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/ts_classifier.sv
module ts_classifier
    import atr_ts_pkg::*;
(
    input  logic [7:0] raw,
    output ts_kind_t   kind,
    output logic [7:0] value
);
    logic [7:0] flipped;

    for (genvar b = 0; b < 8; b++) begin : g_flip
        assign flipped[b] = ~raw[7-b];
    end

    always_comb begin
        if (raw == RAW_TS_DIRECT) begin
            kind  = TS_DIRECT;
            value = raw;
        end else if (raw == RAW_TS_INVERSE) begin
            kind  = TS_INVERSE;
            value = flipped;
        end else begin
            kind  = TS_INVALID;
            value = raw;
        end
    end
endmodule

// File: rtl/atr_ts_monitor.sv
module atr_ts_monitor
    import atr_ts_pkg::*;
#(
    parameter int EARLY_CYCLES = 400,
    parameter int LATE_CYCLES  = 40000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       card_vcc,
    input  logic       card_rst_n,
    input  logic       card_clk,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       activated,
    output logic       ts_seen,
    output logic       ts_bad,
    output logic       inverse_conv,
    output logic [7:0] ts_byte,
    output logic       atr_early,
    output logic       atr_late
);
    localparam int CNT_W = $clog2(LATE_CYCLES + 1);

    logic [2:0]       lines_s;
    logic             vcc_s;
    logic             crst_n_s;
    logic             cclk_s;
    logic             hold;
    logic             clk_rise;
    logic [CNT_W-1:0] cycle_cnt;
    logic             cnt_full;
    ts_kind_t         ts_kind;
    logic [7:0]       ts_value;
    mon_state_t       state_q;
    mon_state_t       state_nx;
    logic             take_ts;

    card_line_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_in ({card_vcc, card_rst_n, card_clk}),
        .lines_s  (lines_s)
    );

    assign {vcc_s, crst_n_s, cclk_s} = lines_s;
    assign hold = ~vcc_s | ~crst_n_s;

    card_cycle_counter #(.LIMIT(LATE_CYCLES), .CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (hold),
        .card_clk_s (cclk_s),
        .clk_rise   (clk_rise),
        .count      (cycle_cnt),
        .at_limit   (cnt_full)
    );

    ts_classifier u_cls (
        .raw   (rx_data),
        .kind  (ts_kind),
        .value (ts_value)
    );

    // powered-and-clocked indication, independent of the card reset line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            activated <= 1'b0;
        end else if (!vcc_s) begin
            activated <= 1'b0;
        end else if (clk_rise) begin
            activated <= 1'b1;
        end
    end

    assign take_ts = rx_valid && (state_q != ST_DONE);

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_WAIT: begin
                if (rx_valid)      state_nx = ST_DONE;
                else if (cnt_full) state_nx = ST_OVERDUE;
            end
            ST_OVERDUE: begin
                if (rx_valid)      state_nx = ST_DONE;
            end
            ST_DONE:               state_nx = ST_DONE;
            default:               state_nx = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else if (hold) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts_seen      <= 1'b0;
            ts_bad       <= 1'b0;
            inverse_conv <= 1'b0;
            ts_byte      <= 8'h00;
            atr_early    <= 1'b0;
            atr_late     <= 1'b0;
        end else if (hold) begin
            ts_seen      <= 1'b0;
            ts_bad       <= 1'b0;
            inverse_conv <= 1'b0;
            ts_byte      <= 8'h00;
            atr_early    <= 1'b0;
            atr_late     <= 1'b0;
        end else begin
            if (take_ts) begin
                ts_seen      <= 1'b1;
                ts_byte      <= ts_value;
                inverse_conv <= (ts_kind == TS_INVERSE);
                ts_bad       <= (ts_kind == TS_INVALID);
                atr_early    <= (cycle_cnt < CNT_W'(EARLY_CYCLES));
            end
            if ((state_q != ST_DONE) && cnt_full) begin
                atr_late <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/atr_ts_monitor_chk.sv
module atr_ts_monitor_chk #(
    parameter int LATE_CYCLES = 40000,
    parameter int CNT_W       = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hold,
    input logic             vcc_s,
    input logic [CNT_W-1:0] cycle_cnt,
    input logic             activated,
    input logic             ts_seen,
    input logic             ts_bad,
    input logic             inverse_conv,
    input logic [7:0]       ts_byte,
    input logic             atr_early,
    input logic             atr_late
);
    a_r1_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (!ts_seen && !ts_bad && !inverse_conv && !atr_early
                  && !atr_late && ts_byte == 8'h00));

    a_r2_supply_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_s |=> !activated);

    a_r8_late_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (atr_late && !hold) |=> atr_late);

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_cnt <= CNT_W'(LATE_CYCLES));

    a_r10_ts_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_seen && !hold) |=> ($stable(ts_byte) && $stable(inverse_conv)
                                && $stable(ts_bad)));

    a_r6_early_needs_ts: assert property (@(posedge clk) disable iff (!rst_n)
        atr_early |-> ts_seen);

    a_r5_bad_not_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        ts_bad |-> !inverse_conv);
endmodule

bind atr_ts_monitor atr_ts_monitor_chk #(
    .LATE_CYCLES (LATE_CYCLES),
    .CNT_W       (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold         (hold),
    .vcc_s        (vcc_s),
    .cycle_cnt    (cycle_cnt),
    .activated    (activated),
    .ts_seen      (ts_seen),
    .ts_bad       (ts_bad),
    .inverse_conv (inverse_conv),
    .ts_byte      (ts_byte),
    .atr_early    (atr_early),
    .atr_late     (atr_late)
);

// File: tb/test_atr_ts_monitor.sv
`timescale 1ns/1ps
module test_atr_ts_monitor;
    localparam int EARLY = 20;
    localparam int LATE  = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       card_vcc = 1'b0;
    logic       card_rst_n = 1'b0;
    logic       card_clk = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       activated, ts_seen, ts_bad, inverse_conv, atr_early, atr_late;
    logic [7:0] ts_byte;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    atr_ts_monitor #(.EARLY_CYCLES(EARLY), .LATE_CYCLES(LATE)) i_atr_ts_monitor (
        .clk(clk), .rst_n(rst_n), .card_vcc(card_vcc), .card_rst_n(card_rst_n),
        .card_clk(card_clk), .rx_valid(rx_valid), .rx_data(rx_data),
        .activated(activated), .ts_seen(ts_seen), .ts_bad(ts_bad),
        .inverse_conv(inverse_conv), .ts_byte(ts_byte),
        .atr_early(atr_early), .atr_late(atr_late)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic card_edges(input int n);
        for (int i = 0; i < n; i++) begin
            card_clk = 1'b1; settle(2);
            card_clk = 1'b0; settle(2);
        end
        settle(6);
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0; rx_data = 8'h00;
        settle(3);
    endtask

    task automatic start_session();
        card_vcc = 1'b1; card_rst_n = 1'b0; settle(6);
        card_rst_n = 1'b1; settle(6);
    endtask

    task automatic t_reset_state();
        check("R1", "ts_seen", ts_seen, 0);
        check("R1", "ts_byte", ts_byte, 0);
        check("R1", "atr_late", atr_late, 0);
        check("R2", "activated", activated, 0);
    endtask

    task automatic t_activation();
        card_vcc = 1'b1; settle(6);
        check("R2", "activated without edges", activated, 0);
        card_edges(1);
        check("R2", "activated after edge", activated, 1);
        send_byte(8'h3B);
        check("R1", "strobe ignored in reset", ts_seen, 0);
        check("R1", "ts_byte in reset", ts_byte, 0);
    endtask

    task automatic t_direct();
        start_session(); card_edges(EARLY + 5);
        send_byte(8'h3B);
        check("R3", "ts_seen", ts_seen, 1);
        check("R3", "inverse_conv", inverse_conv, 0);
        check("R3", "ts_bad", ts_bad, 0);
        check("R3", "ts_byte", ts_byte, 8'h3B);
        check("R7", "atr_early", atr_early, 0);
    endtask

    task automatic t_inverse();
        start_session(); card_edges(30);
        send_byte(8'h03);
        check("R4", "inverse_conv", inverse_conv, 1);
        check("R4", "ts_byte", ts_byte, 8'h3F);
        check("R4", "ts_bad", ts_bad, 0);
        send_byte(8'h3B);
        check("R10", "ts_byte after 2nd", ts_byte, 8'h3F);
        check("R10", "inverse after 2nd", inverse_conv, 1);
        send_byte(8'h55);
        check("R10", "ts_bad after 3rd", ts_bad, 0);
    endtask

    task automatic t_bad();
        start_session(); card_edges(30);
        send_byte(8'hA5);
        check("R5", "ts_seen", ts_seen, 1);
        check("R5", "ts_bad", ts_bad, 1);
        check("R5", "inverse_conv", inverse_conv, 0);
        check("R5", "ts_byte", ts_byte, 8'hA5);
    endtask

    task automatic t_early_bounds();
        start_session(); card_edges(EARLY - 1);
        send_byte(8'h3B);
        check("R6", "early one short", atr_early, 1);
        start_session(); card_edges(EARLY);
        send_byte(8'h3B);
        check("R7", "early at limit", atr_early, 0);
    endtask

    task automatic t_late();
        start_session(); card_edges(LATE - 1);
        check("R8", "late one short", atr_late, 0);
        card_edges(1);
        check("R8", "late at limit", atr_late, 1);
        card_edges(60);
        check("R9", "late past wrap point", atr_late, 1);
        send_byte(8'h3B);
        check("R8", "late after ts", atr_late, 1);
        check("R8", "ts_seen after late", ts_seen, 1);
        check("R8", "ts_byte after late", ts_byte, 8'h3B);
    endtask

    task automatic t_rearm();
        card_rst_n = 1'b0; settle(6);
        check("R11", "late cleared", atr_late, 0);
        check("R11", "ts_seen cleared", ts_seen, 0);
        card_rst_n = 1'b1; settle(6);
        card_edges(30);
        send_byte(8'h3B);
        check("R11", "fresh ts_seen", ts_seen, 1);
        check("R11", "fresh late", atr_late, 0);
        check("R11", "fresh early", atr_early, 0);
    endtask

    task automatic t_power_loss();
        card_vcc = 1'b0; settle(6);
        check("R2", "activated after supply loss", activated, 0);
        check("R1", "ts_seen after supply loss", ts_seen, 0);
    endtask

    initial begin
        settle(5);
        rst_n = 1'b1;
        settle(5);
        t_reset_state();
        t_activation();
        t_direct();
        t_inverse();
        t_bad();
        t_early_bounds();
        t_late();
        t_rearm();
        t_power_loss();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule